// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a general-purpose timer. It sits beside a shared counter and takes that counter's value, its count direction, the reload limit, the update pulse and the wrap pulse (overflow when counting up, underflow when counting down). It works in one of two roles. As a compare unit it drives a reference level and a polarity-adjusted pin from one of eight behaviours. As a capture unit it stores the counter value on a chosen input edge.

In the compare role, the reference level is held by a two-state machine with the states `REF_LOW` and `REF_HIGH`. The named transitions are:

- **hold**: frozen mode.
- **set-on-match**, **clear-on-match** and **toggle-on-match**.
- **force-low** and **force-high**.
- **pwm-track**: the level follows the comparison result in both PWM modes.
- **ext-clear**: this transition takes priority over all others and sends the machine to `REF_LOW`.

A compare value can be loaded at once, or staged and made active at the next update pulse. The capture/compare flag reports matches and captures. An overcapture flag records a capture that lands while the flag is still set.

The role select is taken into the channel only while the channel is disabled. A software generate strobe creates an event in either role.

Top module: `tcc_channel`

## Requirements
- R1: During and after reset, the reference, pin, capture/compare flag, overcapture flag and register value are all 0, and the channel is in the compare role.
- R2: Mode codes and their effect on the reference: 4 forces it low and 5 forces it high, one cycle after the clock edge. Mode 0 (frozen) keeps the current level whatever the counter does.
- R3: Mode 1 drives the reference high after the clock edge where the counter equals the active compare value. Mode 2 drives it low after such an edge. Mode 3 inverts it after such an edge.
- R4: Mode 6 gives reference = (counter < compare) when counting up and reference = (counter <= compare) when counting down. Mode 7 gives the inverse of mode 6. The result is registered one cycle after the counter value.
- R5: While clear enable is 1, a high external clear input puts the reference at 0 one cycle later in every mode. With clear enable at 0, the clear input has no effect.
- R6: The pin equals the reference XOR the output polarity bit when the channel is enabled and in the compare role. Otherwise the pin is 0.
- R7: When compare <= reload, the flag sets one cycle after the counter equals the compare value. When compare > reload, a match does not set the flag; instead the flag sets one cycle after a wrap pulse, in both count directions.
- R8: With preload off, a write becomes the active compare value at once. With preload on, the written value is readable at once but becomes active only at the next update pulse.
- R9: The capture edge is selected by {secondary, main} polarity bits: 00 rising, 01 falling, 11 both, 10 reserved (no capture). When the channel is enabled, a selected edge copies the counter into the register and sets the flag.
- R10: A capture, by edge or by the generate strobe, taken while the flag is already 1 sets the overcapture flag.
- R11: In the capture role, a register read strobe clears the flag, and register writes leave the register unchanged.
- R12: The generate strobe sets the flag in the compare role. In the capture role it captures the counter and sets the flag, and it also sets overcapture if the flag was already 1.
- R13: The role select (0 = compare, any other value = capture) is taken in only on cycles when the channel enable is 0.
- R14: The flag clear input clears both the capture/compare flag and the overcapture flag. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Counter value |
| cnt_down_i | input | 1 | 1 when the counter counts down |
| reload_i | input | CNT_W | Active reload value |
| update_i | input | 1 | Update event pulse |
| wrap_i | input | 1 | Overflow/underflow pulse |
| clr_en_i | input | 1 | External clear enable |
| clr_in_i | input | 1 | External clear input |
| chan_in_i | input | 1 | Channel input for capture |
| mode_i | input | 3 | Compare behaviour code |
| sel_i | input | 2 | Role select, 0 = compare |
| pol_main_i | input | 1 | Output polarity / capture edge main bit |
| pol_sec_i | input | 1 | Capture edge secondary bit |
| chan_en_i | input | 1 | Channel enable |
| preload_en_i | input | 1 | Compare preload enable |
| ccr_wr_i | input | 1 | Register write strobe |
| ccr_wdata_i | input | CNT_W | Register write data |
| ccr_rd_i | input | 1 | Register read strobe |
| gen_i | input | 1 | Software generate strobe |
| flag_clr_i | input | 1 | Clear both flags |
| ref_o | output | 1 | Reference level |
| pin_o | output | 1 | Polarity-adjusted pin |
| ccr_o | output | CNT_W | Compare preload value or captured value |
| flag_o | output | 1 | Capture/compare flag |
| ovc_o | output | 1 | Overcapture flag |

## Verification
The bench targets the edges of each comparison:

- It sweeps the PWM modes across every counter value, in both directions and at several compare values. An off-by-one between `<` and `<=` therefore shows up as a wrong reference level at exactly one counter value.
- It drives a compare value above the reload, both at that value and at a wrap pulse. A design that matched blindly would raise the flag early, and one that ignored the wrap would never raise it.
- It makes a preloaded write and then counts through the new value before the update pulse. A design that applied the write at once would set the flag too soon.
- It covers every polarity pair on both input edges, including the reserved one. It also checks that a capture landing on a set flag raises overcapture and that a role change while enabled is refused. A design that got these wrong would capture on the wrong edge or let a write overwrite the captured value.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [2:0] {
        OCM_FROZEN = 3'd0,
        OCM_SET    = 3'd1,
        OCM_CLR    = 3'd2,
        OCM_TOG    = 3'd3,
        OCM_FLOW   = 3'd4,
        OCM_FHIGH  = 3'd5,
        OCM_PWM1   = 3'd6,
        OCM_PWM2   = 3'd7
    } ocm_e;

    typedef enum logic {
        REF_LOW  = 1'b0,
        REF_HIGH = 1'b1
    } ref_state_e;

    // encoded as {secondary, main}
    typedef enum logic [1:0] {
        EDG_RISE = 2'b00,
        EDG_FALL = 2'b01,
        EDG_RSVD = 2'b10,
        EDG_BOTH = 2'b11
    } edge_sel_e;

endpackage

// File: rtl/tcc_ref_fsm.sv
module tcc_ref_fsm
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             down,
    input  logic             clr_force,
    output logic             ref_o
);

    ref_state_e state_q, state_d;
    ocm_e       mode_e;
    logic       match, below, pwm_lvl;

    assign mode_e  = ocm_e'(mode);
    assign match   = (cnt == cmp);
    assign below   = (cnt < cmp);
    assign pwm_lvl = down ? (below || match) : below;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REF_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (active) begin
            unique case (mode_e)
                OCM_FROZEN: state_d = state_q;
                OCM_SET:    if (match) state_d = REF_HIGH;
                OCM_CLR:    if (match) state_d = REF_LOW;
                OCM_TOG:    if (match) state_d = (state_q == REF_HIGH) ? REF_LOW : REF_HIGH;
                OCM_FLOW:   state_d = REF_LOW;
                OCM_FHIGH:  state_d = REF_HIGH;
                OCM_PWM1:   state_d = pwm_lvl ? REF_HIGH : REF_LOW;
                OCM_PWM2:   state_d = pwm_lvl ? REF_LOW : REF_HIGH;
            endcase
        end
        if (clr_force) state_d = REF_LOW;
    end

    always_comb begin
        ref_o = (state_q == REF_HIGH);
    end

    // R2
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mode == 3'd5 && !clr_force) |=> ref_o);

    // R5
    ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_force |=> !ref_o);

endmodule

// File: rtl/tcc_edge_sel.sv
module tcc_edge_sel
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig,
    input  logic [1:0] sel,
    input  logic       en,
    output logic       edge_o
);

    logic sig_d;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_d <= 1'b0;
        else        sig_d <= sig;
    end

    assign rise = sig & ~sig_d;
    assign fall = ~sig & sig_d;

    always_comb begin
        edge_o = 1'b0;
        unique case (edge_sel_e'(sel))
            EDG_RISE: edge_o = en & rise;
            EDG_FALL: edge_o = en & fall;
            EDG_BOTH: edge_o = en & (rise | fall);
            EDG_RSVD: edge_o = 1'b0;
        endcase
    end

    // R9
    rsvd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10) |-> !edge_o);

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             update_i,
    input  logic             wrap_i,
    input  logic             clr_en_i,
    input  logic             clr_in_i,
    input  logic             chan_in_i,
    input  logic [2:0]       mode_i,
    input  logic [1:0]       sel_i,
    input  logic             pol_main_i,
    input  logic             pol_sec_i,
    input  logic             chan_en_i,
    input  logic             preload_en_i,
    input  logic             ccr_wr_i,
    input  logic [CNT_W-1:0] ccr_wdata_i,
    input  logic             ccr_rd_i,
    input  logic             gen_i,
    input  logic             flag_clr_i,
    output logic             ref_o,
    output logic             pin_o,
    output logic [CNT_W-1:0] ccr_o,
    output logic             flag_o,
    output logic             ovc_o
);

    localparam logic [1:0] SEL_CMP = 2'd0;

    logic [1:0]       sel_q;
    logic [CNT_W-1:0] shadow_q, act_q;
    logic             flag_q, ovc_q;
    logic             cap_mode, cap_edge, cap_evt, out_hit;
    logic             match, beyond;

    assign cap_mode = (sel_q != SEL_CMP);
    assign match    = (cnt_i == act_q);
    assign beyond   = (act_q > reload_i);
    assign out_hit  = !cap_mode && ((match && !beyond) || (beyond && wrap_i) || gen_i);
    assign cap_evt  = cap_mode && (cap_edge || gen_i);

    tcc_ref_fsm #(.CNT_W(CNT_W)) ref_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (!cap_mode),
        .mode     (mode_i),
        .cnt      (cnt_i),
        .cmp      (act_q),
        .down     (cnt_down_i),
        .clr_force(clr_en_i && clr_in_i),
        .ref_o    (ref_o)
    );

    tcc_edge_sel edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (chan_in_i),
        .sel   ({pol_sec_i, pol_main_i}),
        .en    (chan_en_i && cap_mode),
        .edge_o(cap_edge)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= SEL_CMP;
            shadow_q <= '0;
            act_q    <= '0;
            flag_q   <= 1'b0;
            ovc_q    <= 1'b0;
        end else begin
            if (!chan_en_i) sel_q <= sel_i;

            if (cap_evt)                     shadow_q <= cnt_i;
            else if (!cap_mode && ccr_wr_i)  shadow_q <= ccr_wdata_i;

            if (!cap_mode) begin
                if (ccr_wr_i && !preload_en_i) act_q <= ccr_wdata_i;
                else if (update_i)             act_q <= shadow_q;
            end

            if (out_hit || cap_evt)                        flag_q <= 1'b1;
            else if (flag_clr_i || (cap_mode && ccr_rd_i)) flag_q <= 1'b0;

            if (cap_evt && flag_q) ovc_q <= 1'b1;
            else if (flag_clr_i)   ovc_q <= 1'b0;
        end
    end

    assign pin_o  = chan_en_i && !cap_mode && (ref_o ^ pol_main_i);
    assign ccr_o  = shadow_q;
    assign flag_o = flag_q;
    assign ovc_o  = ovc_q;

    // R8
    preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en_i && !update_i) |=> $stable(act_q));

    // R10
    ovc_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovc_q) |-> $past(flag_q));

    // R11
    cap_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && ccr_wr_i && !cap_evt) |=> $stable(ccr_o));

    // R13
    sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en_i |=> $stable(sel_q));

endmodule

// File: tb/tcc_channel_tb_top.sv
module tcc_channel_tb_top;

    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n;
    logic [W-1:0] cnt, reload, wdata;
    logic         down, update, wrap, clr_en, clr_in, chan_in;
    logic [2:0]   mode;
    logic [1:0]   sel;
    logic         pol_m, pol_s, chan_en, preload, ccr_wr, ccr_rd, gen, flag_clr;
    logic         ref_o, pin_o, flag_o, ovc_o;
    logic [W-1:0] ccr_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    tcc_channel #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_down_i(down), .reload_i(reload),
        .update_i(update), .wrap_i(wrap), .clr_en_i(clr_en), .clr_in_i(clr_in),
        .chan_in_i(chan_in), .mode_i(mode), .sel_i(sel), .pol_main_i(pol_m),
        .pol_sec_i(pol_s), .chan_en_i(chan_en), .preload_en_i(preload),
        .ccr_wr_i(ccr_wr), .ccr_wdata_i(wdata), .ccr_rd_i(ccr_rd), .gen_i(gen),
        .flag_clr_i(flag_clr), .ref_o(ref_o), .pin_o(pin_o), .ccr_o(ccr_o),
        .flag_o(flag_o), .ovc_o(ovc_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int v);
        ccr_wr = 1'b1; wdata = v[W-1:0];
        step();
        ccr_wr = 1'b0;
    endtask

    task automatic clrf;
        flag_clr = 1'b1; cnt = 8'hFF;
        step();
        flag_clr = 1'b0;
    endtask

    task automatic sweep_ref(input string tag, input int c, input int lo, input int hi, input bit after_hi);
        for (int k = lo; k <= hi; k++) begin
            cnt = k[W-1:0];
            step();
            chk(tag, 32'(ref_o), 32'((k >= c) ? after_hi : !after_hi));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 got=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int exp_ccr;
        rst_n = 0; cnt = '0; reload = 8'd11; wdata = '0; down = 0; update = 0; wrap = 0;
        clr_en = 0; clr_in = 0; chan_in = 0; mode = 3'd0; sel = 2'd0; pol_m = 0; pol_s = 0;
        chan_en = 0; preload = 0; ccr_wr = 0; ccr_rd = 0; gen = 0; flag_clr = 0;
        repeat (3) step();
        // R1 reset state
        chk("R1 ref", 32'(ref_o), 0);
        chk("R1 pin", 32'(pin_o), 0);
        chk("R1 flag", 32'(flag_o), 0);
        chk("R1 ovc", 32'(ovc_o), 0);
        chk("R1 ccr", 32'(ccr_o), 0);
        rst_n = 1;
        step();
        chan_en = 1;

        // R4 R6 R7: PWM sweep
        for (int ci = 0; ci < 4; ci++)
            for (int m = 6; m < 8; m++)
                for (int d = 0; d < 2; d++) begin
                    int c;
                    c = ci * 3 + 1;
                    mode = m[2:0]; down = d[0]; pol_m = d[0] ^ m[0];
                    wr(c);
                    clrf();
                    for (int k = 0; k < 12; k++) begin
                        bit e;
                        cnt = k[W-1:0];
                        step();
                        e = d[0] ? (k <= c) : (k < c);
                        if (m == 7) e = !e;
                        chk("R4 pwm ref", 32'(ref_o), 32'(e));
                        chk("R6 pin", 32'(pin_o), 32'(e ^ pol_m));
                        chk("R7 match flag", 32'(flag_o), 32'(k >= c));
                    end
                end

        // R7 compare beyond reload
        mode = 3'd0; down = 0;
        wr(20); clrf();
        for (int k = 0; k < 12; k++) begin
            cnt = k[W-1:0]; step();
            chk("R7 no early flag", 32'(flag_o), 0);
        end
        cnt = 8'd20; step();
        chk("R7 match ignored beyond", 32'(flag_o), 0);
        cnt = 8'd0; wrap = 1; step(); wrap = 0;
        chk("R7 overflow flag", 32'(flag_o), 1);
        down = 1; clrf();
        cnt = 8'd11; wrap = 1; step(); wrap = 0;
        chk("R7 underflow flag", 32'(flag_o), 1);
        down = 0;

        // R2 R3 match modes
        wr(5);
        mode = 3'd4; step();
        chk("R2 force low", 32'(ref_o), 0);
        mode = 3'd1; sweep_ref("R3 set", 5, 0, 8, 1);
        mode = 3'd2; sweep_ref("R3 clear", 5, 0, 8, 0);
        mode = 3'd3; sweep_ref("R3 toggle a", 5, 0, 8, 1);
        sweep_ref("R3 toggle b", 5, 0, 8, 0);

        // R2 frozen
        mode = 3'd5; step();
        chk("R2 force high", 32'(ref_o), 1);
        mode = 3'd0;
        for (int k = 0; k < 9; k++) begin
            cnt = k[W-1:0]; step();
            chk("R2 frozen high", 32'(ref_o), 1);
        end
        mode = 3'd4; step();
        mode = 3'd0;
        for (int k = 0; k < 9; k++) begin
            cnt = k[W-1:0]; step();
            chk("R2 frozen low", 32'(ref_o), 0);
        end

        // R5 external clear
        mode = 3'd5; step();
        clr_en = 1; clr_in = 1; step();
        chk("R5 cleared", 32'(ref_o), 0);
        clr_in = 0; step();
        chk("R5 released", 32'(ref_o), 1);
        clr_en = 0; clr_in = 1; step();
        chk("R5 disabled clear", 32'(ref_o), 1);
        clr_in = 0;

        // R6 pin gating
        pol_m = 1; chan_en = 0; step();
        chk("R6 disabled pin", 32'(pin_o), 0);
        chan_en = 1; #1;
        chk("R6 inverted pin", 32'(pin_o), 0);
        pol_m = 0; #1;
        chk("R6 direct pin", 32'(pin_o), 1);

        // R8 preload
        mode = 3'd0; preload = 0; wr(9);
        preload = 1; wr(5);
        chk("R8 shadow readable", 32'(ccr_o), 5);
        clrf();
        cnt = 8'd5; step();
        chk("R8 not yet active", 32'(flag_o), 0);
        cnt = 8'd9; step();
        chk("R8 old value active", 32'(flag_o), 1);
        clrf();
        update = 1; step(); update = 0;
        cnt = 8'd5; step();
        chk("R8 active after update", 32'(flag_o), 1);
        preload = 0; wr(3); clrf();
        cnt = 8'd3; step();
        chk("R8 immediate", 32'(flag_o), 1);

        // R12 generate in compare role
        clrf();
        gen = 1; step(); gen = 0;
        chk("R12 gen flag", 32'(flag_o), 1);

        // R13 enter capture role
        chan_en = 0; sel = 2'd1; step();
        chan_en = 1; pol_m = 0; pol_s = 0;
        exp_ccr = 3;
        clrf();
        chk("R13 pin in capture", 32'(pin_o), 0);

        // R9 edge selection sweep
        for (int pp = 0; pp < 4; pp++) begin
            bit cap;
            pol_m = pp[0]; pol_s = pp[1];
            clrf();
            chan_in = 1; cnt = 8'(pp * 20 + 1); step();
            cap = (pp == 0) || (pp == 3);
            if (cap) exp_ccr = pp * 20 + 1;
            chk("R9 rise ccr", 32'(ccr_o), 32'(exp_ccr));
            chk("R9 rise flag", 32'(flag_o), 32'(cap));
            clrf();
            chan_in = 0; cnt = 8'(pp * 20 + 2); step();
            cap = (pp == 1) || (pp == 3);
            if (cap) exp_ccr = pp * 20 + 2;
            chk("R9 fall ccr", 32'(ccr_o), 32'(exp_ccr));
            chk("R9 fall flag", 32'(flag_o), 32'(cap));
        end

        // R10 overcapture
        pol_m = 0; pol_s = 0; clrf();
        chan_in = 1; cnt = 8'd50; step();
        chk("R10 first ovc", 32'(ovc_o), 0);
        chan_in = 0; step();
        chan_in = 1; cnt = 8'd60; step();
        chk("R10 second ccr", 32'(ccr_o), 60);
        chk("R10 overcapture", 32'(ovc_o), 1);

        // R11 read clear
        ccr_rd = 1; step(); ccr_rd = 0;
        chk("R11 read clears", 32'(flag_o), 0);
        chk("R14 ovc kept by read", 32'(ovc_o), 1);
        flag_clr = 1; step(); flag_clr = 0;
        chk("R14 ovc cleared", 32'(ovc_o), 0);
        wr(77);
        chk("R11 write ignored", 32'(ccr_o), 60);

        // R12 generate in capture role
        cnt = 8'd90; gen = 1; step(); gen = 0;
        chk("R12 gen capture", 32'(ccr_o), 90);
        chk("R12 gen flag cap", 32'(flag_o), 1);
        chk("R12 gen no ovc", 32'(ovc_o), 0);
        cnt = 8'd91; gen = 1; step(); gen = 0;
        chk("R12 gen ovc", 32'(ovc_o), 1);

        // R14 set wins over clear
        cnt = 8'd92; gen = 1; flag_clr = 1; step(); gen = 0; flag_clr = 0;
        chk("R14 set wins", 32'(flag_o), 1);

        // R13 select locked while enabled
        sel = 2'd0; step();
        wr(33);
        chk("R13 still capture", 32'(ccr_o), 92);
        chan_en = 0; step();
        wr(33);
        chk("R13 compare after disable", 32'(ccr_o), 33);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule